// File: doc/BRIEF.md
# Double-to-Single Round-to-Odd Narrower

This block takes one IEEE 754 binary64 value and produces the binary32 value nearest below it in magnitude, with the last kept mantissa bit forced to one whenever any discarded bit was set. This rounding rule, round-to-odd, is not the usual round-to-nearest-even. Its purpose is to keep a later narrowing step correct: a binary32 result made this way can be rounded once more, to binary16, and give the same answer as a single direct rounding from binary64. Exact conversions pass through unchanged. The block handles normal, subnormal, zero, infinite and NaN inputs, and reports overflow, underflow, inexact and invalid flags.

Work is sequenced by a three-state controller. In `ST_IDLE` the block waits. A `start` pulse latches the operand and the two mode inputs (`dflt_nan`, `flush_zero`) and moves to `ST_CLASSIFY`, where the operand class and the subnormal shift count are registered. The next edge moves to `ST_PACK`, where the result and flags are registered, `done` pulses, and control returns to `ST_IDLE`. Every conversion therefore takes three edges from the accepting edge to the result edge, and the outputs hold until the next result.

Field positions follow the standard encodings. Binary64 has sign bit 63, exponent bits 62:52 (bias 1023) and fraction bits 51:0. Binary32 has sign bit 31, exponent bits 30:23 (bias 127) and fraction bits 22:0. The top fraction bit of a NaN is its quiet bit.

Top module: `dbl_to_sgl_odd`

## Requirements
- R1: A normal input whose rebiased exponent (input exponent minus 896) lies in 1..254 and whose low 29 fraction bits are zero yields the same sign, exponent = input exponent - 896, fraction = input fraction bits 51:29, with no flag raised.
- R2: For the same exponent range with any of fraction bits 28:0 set, the result takes the truncated fraction bits 51:29 and forces result bit 0 to 1; flag_inx is 1 and the magnitude is never rounded up.
- R3: An input exponent of 1151..2046 gives the largest finite binary32 with the input sign (magnitude 0x7F7FFFFF) and never infinity, with flag_ovf and flag_inx set.
- R4: An input exponent of 1..896 with flush_zero low gives a binary32 subnormal: the 53-bit significand shifted right by 926 minus the exponent (shifts of 53 or more keep nothing), with bit 0 forced to 1 if any bit was shifted out; flag_unf and flag_inx are both 1 exactly when a bit was lost.
- R5: A zero input gives a zero with the same sign and no flags. A binary64 subnormal input (exponent 0, fraction nonzero) with flush_zero low gives the smallest binary32 subnormal (magnitude 0x00000001) with the same sign, flag_unf and flag_inx.
- R6: With flush_zero high, any nonzero input whose result would be subnormal or tiny (input exponent 0..896) gives a zero with the same sign, flag_unf and flag_inx.
- R7: An infinite input gives the binary32 infinity of the same sign, with no flag.
- R8: With dflt_nan low, a NaN input gives sign kept, exponent all ones, result bit 22 set and bits 21:0 = input fraction bits 50:29. flag_inv is 1 exactly when input fraction bit 51 was 0 (a signaling NaN).
- R9: With dflt_nan high, every NaN input gives 0x7FC00000, and flag_inv follows the same rule as R8.
- R10: After reset, busy, done, the result and all flags are 0. A start seen in ST_IDLE is accepted. busy is high for the next two cycles. done is high for one cycle, starting three edges after acceptance. A start or any input change while busy has no effect on that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a conversion, accepted only when idle |
| dbl_in | input | 64 | Binary64 operand |
| dflt_nan | input | 1 | Replace every NaN result with the default quiet NaN |
| flush_zero | input | 1 | Flush tiny results to signed zero |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse: result and flags valid |
| sgl_out | output | 32 | Binary32 result |
| flag_ovf | output | 1 | Overflow |
| flag_unf | output | 1 | Underflow (tiny and inexact, or flushed) |
| flag_inx | output | 1 | Inexact |
| flag_inv | output | 1 | Invalid (signaling NaN operand) |

## Verification
Every one of the 2048 exponent codes is tried with five fraction patterns: all zeros, all ones, only the lowest bit, only the lowest kept bit (bit 29), and a pseudo-random value. The signs alternate. Together these patterns separate exact results from inexact ones, show whether the odd bit is forced only when bits are lost, and locate the edges of the normal range, the overflow range and the subnormal shift range (including shifts at and beyond the significand width). Flush mode is swept across the tiny exponents. NaNs with quiet and signaling payloads are run in both NaN modes, which separates payload truncation from the default NaN and shows that invalid depends only on the quiet bit. A start issued while busy, with a different operand, shows that an accepted conversion cannot be disturbed.

// File: rtl/rto_pkg.sv
package rto_pkg;

    // Operand class decided in the classify state
    typedef enum logic [2:0] {
        CAT_ZERO,
        CAT_DIN,
        CAT_INF,
        CAT_QNAN,
        CAT_SNAN,
        CAT_OVF,
        CAT_NORM,
        CAT_SUB
    } cat_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLASSIFY,
        ST_PACK
    } state_e;

endpackage

// File: rtl/rto_classify.sv
module rto_classify
    import rto_pkg::*;
#(
    parameter int IN_EW  = 11,
    parameter int IN_FW  = 52,
    parameter int OUT_EW = 8,
    parameter int OUT_FW = 23,
    parameter int SH_W   = 6
) (
    input  logic [IN_EW-1:0] exp_in,
    input  logic [IN_FW-1:0] frac_in,
    output cat_e             cat,
    output logic [SH_W-1:0]  sub_shift
);

    localparam int IN_BIAS  = (1 << (IN_EW - 1)) - 1;
    localparam int OUT_BIAS = (1 << (OUT_EW - 1)) - 1;
    localparam int EXP_OFF  = IN_BIAS - OUT_BIAS;
    localparam int EXP_TOP  = EXP_OFF + (1 << OUT_EW) - 2;
    localparam int EXP_ALL  = (1 << IN_EW) - 1;
    localparam int SIG_W    = IN_FW + 1;
    localparam int SUB_BASE = IN_FW - OUT_FW + EXP_OFF + 1;

    int e_i;
    int ediff;

    always_comb begin
        e_i   = int'(exp_in);
        ediff = SUB_BASE - e_i;
        if (ediff > SIG_W) ediff = SIG_W;   // R4: nothing survives past full width
        if (ediff < 0)     ediff = 0;
        sub_shift = SH_W'(ediff);

        if (e_i == EXP_ALL) begin
            if (frac_in == '0)           cat = CAT_INF;
            else if (frac_in[IN_FW-1])   cat = CAT_QNAN;
            else                         cat = CAT_SNAN;
        end else if (e_i == 0) begin
            cat = (frac_in == '0) ? CAT_ZERO : CAT_DIN;
        end else if (e_i > EXP_TOP) begin
            cat = CAT_OVF;
        end else if (e_i > EXP_OFF) begin
            cat = CAT_NORM;
        end else begin
            cat = CAT_SUB;
        end
    end

endmodule

// File: rtl/rto_jam_shift.sv
module rto_jam_shift #(
    parameter int SIG_W  = 53,
    parameter int OUT_FW = 23,
    parameter int SH_W   = 6
) (
    input  logic [SIG_W-1:0]  sig,
    input  logic [SH_W-1:0]   shamt,
    output logic [OUT_FW-1:0] kept,
    output logic              lost
);

    logic [SIG_W-1:0] dropped;

    assign kept = OUT_FW'(sig >> shamt);

    // One sticky term per significand bit: set if that bit falls off the end
    for (genvar i = 0; i < SIG_W; i++) begin : g_drop
        assign dropped[i] = sig[i] & (SH_W'(i) < shamt);
    end

    assign lost = |dropped;

endmodule

// File: rtl/dbl_to_sgl_odd.sv
module dbl_to_sgl_odd
    import rto_pkg::*;
#(
    parameter int IN_EW  = 11,
    parameter int IN_FW  = 52,
    parameter int OUT_EW = 8,
    parameter int OUT_FW = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [IN_EW+IN_FW:0]     dbl_in,
    input  logic                     dflt_nan,
    input  logic                     flush_zero,
    output logic                     busy,
    output logic                     done,
    output logic [OUT_EW+OUT_FW:0]   sgl_out,
    output logic                     flag_ovf,
    output logic                     flag_unf,
    output logic                     flag_inx,
    output logic                     flag_inv
);

    localparam int IN_W     = 1 + IN_EW + IN_FW;
    localparam int OUT_W    = 1 + OUT_EW + OUT_FW;
    localparam int SIG_W    = IN_FW + 1;
    localparam int SH_W     = $clog2(SIG_W + 1);
    localparam int IN_BIAS  = (1 << (IN_EW - 1)) - 1;
    localparam int OUT_BIAS = (1 << (OUT_EW - 1)) - 1;
    localparam int EXP_OFF  = IN_BIAS - OUT_BIAS;
    localparam int LOST_W   = IN_FW - OUT_FW;

    localparam logic [OUT_W-2:0] MAX_MAG  = {{(OUT_EW-1){1'b1}}, 1'b0, {OUT_FW{1'b1}}};
    localparam logic [OUT_W-1:0] DEF_NAN  = {1'b0, {OUT_EW{1'b1}}, 1'b1, {(OUT_FW-1){1'b0}}};

    state_e state_q, state_d;

    logic [IN_W-1:0] op_q;
    logic            dn_q, fz_q;
    cat_e            cat_q;
    logic [SH_W-1:0] sh_q;
    logic            done_q;

    logic [OUT_W-1:0] res_q;
    logic             ovf_q, unf_q, inx_q, inv_q;

    logic             op_sign;
    logic [IN_EW-1:0] op_exp;
    logic [IN_FW-1:0] op_frac;

    cat_e             cat_c;
    logic [SH_W-1:0]  sh_c;
    logic [OUT_FW-1:0] sub_keep;
    logic             sub_lost;
    logic [OUT_EW-1:0] norm_exp;
    logic [OUT_FW-1:0] norm_keep;
    logic             norm_lost;
    logic [OUT_FW-2:0] nan_pay;

    logic [OUT_W-1:0] res_c;
    logic             ovf_c, unf_c, inx_c, inv_c;

    assign op_sign = op_q[IN_W-1];
    assign op_exp  = op_q[IN_W-2 -: IN_EW];
    assign op_frac = op_q[IN_FW-1:0];

    rto_classify #(
        .IN_EW (IN_EW),
        .IN_FW (IN_FW),
        .OUT_EW(OUT_EW),
        .OUT_FW(OUT_FW),
        .SH_W  (SH_W)
    ) u_class (
        .exp_in   (op_exp),
        .frac_in  (op_frac),
        .cat      (cat_c),
        .sub_shift(sh_c)
    );

    rto_jam_shift #(
        .SIG_W (SIG_W),
        .OUT_FW(OUT_FW),
        .SH_W  (SH_W)
    ) u_shift (
        .sig  ({1'b1, op_frac}),
        .shamt(sh_q),
        .kept (sub_keep),
        .lost (sub_lost)
    );

    // Normal-range path: rebias and truncate (R1, R2)
    assign norm_exp  = OUT_EW'(op_exp - IN_EW'(EXP_OFF));
    assign norm_keep = op_frac[IN_FW-1 -: OUT_FW];
    assign norm_lost = |op_frac[LOST_W-1:0];
    assign nan_pay   = op_frac[IN_FW-2 -: OUT_FW-1];

    // Result selection by class
    always_comb begin
        res_c = '0;
        ovf_c = 1'b0;
        unf_c = 1'b0;
        inx_c = 1'b0;
        inv_c = 1'b0;
        unique case (cat_q)
            CAT_ZERO: res_c = {op_sign, {(OUT_W-1){1'b0}}};
            CAT_DIN: begin
                unf_c = 1'b1;
                inx_c = 1'b1;
                res_c = fz_q ? {op_sign, {(OUT_W-1){1'b0}}}
                             : {op_sign, {(OUT_W-2){1'b0}}, 1'b1};   // R5 odd jam of nothing
            end
            CAT_INF: res_c = {op_sign, {OUT_EW{1'b1}}, {OUT_FW{1'b0}}};
            CAT_QNAN, CAT_SNAN: begin
                inv_c = (cat_q == CAT_SNAN);
                res_c = dn_q ? DEF_NAN : {op_sign, {OUT_EW{1'b1}}, 1'b1, nan_pay};
            end
            CAT_OVF: begin
                ovf_c = 1'b1;
                inx_c = 1'b1;
                res_c = {op_sign, MAX_MAG};                           // R3
            end
            CAT_NORM: begin
                inx_c = norm_lost;
                res_c = {op_sign, norm_exp, norm_keep[OUT_FW-1:1], norm_keep[0] | norm_lost};
            end
            CAT_SUB: begin
                if (fz_q) begin
                    unf_c = 1'b1;
                    inx_c = 1'b1;
                    res_c = {op_sign, {(OUT_W-1){1'b0}}};            // R6
                end else begin
                    unf_c = sub_lost;
                    inx_c = sub_lost;
                    res_c = {op_sign, {OUT_EW{1'b0}}, sub_keep[OUT_FW-1:1], sub_keep[0] | sub_lost};
                end
            end
            default: res_c = '0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_CLASSIFY;
            ST_CLASSIFY: state_d = ST_PACK;
            ST_PACK:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            dn_q   <= 1'b0;
            fz_q   <= 1'b0;
            cat_q  <= CAT_ZERO;
            sh_q   <= '0;
            done_q <= 1'b0;
            res_q  <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
            inx_q  <= 1'b0;
            inv_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q <= dbl_in;
                        dn_q <= dflt_nan;
                        fz_q <= flush_zero;
                    end
                end
                ST_CLASSIFY: begin
                    cat_q <= cat_c;
                    sh_q  <= sh_c;
                end
                ST_PACK: begin
                    res_q  <= res_c;
                    ovf_q  <= ovf_c;
                    unf_q  <= unf_c;
                    inx_q  <= inx_c;
                    inv_q  <= inv_c;
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign sgl_out  = res_q;
    assign flag_ovf = ovf_q;
    assign flag_unf = unf_q;
    assign flag_inx = inx_q;
    assign flag_inv = inv_q;

endmodule

// File: rtl/dbl_to_sgl_odd_chk.sv
module dbl_to_sgl_odd_chk #(
    parameter int OUT_EW = 8,
    parameter int OUT_FW = 23
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic [OUT_EW+OUT_FW:0] sgl_out,
    input logic                   flag_ovf,
    input logic                   flag_unf,
    input logic                   flag_inx,
    input logic                   flag_inv
);

    localparam int OUT_W = 1 + OUT_EW + OUT_FW;
    localparam logic [OUT_W-2:0] MAX_MAG = {{(OUT_EW-1){1'b1}}, 1'b0, {OUT_FW{1'b1}}};

    a_r3_ovf_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        done && flag_ovf |-> sgl_out[OUT_W-2:0] == MAX_MAG);

    a_r3_ovf_not_tiny: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(flag_ovf && flag_unf));

    a_r2_inexact_odd: assert property (@(posedge clk) disable iff (!rst_n)
        done && flag_inx && (sgl_out[OUT_W-2:0] != '0) |-> sgl_out[0]);

    a_r4_unf_implies_inx: assert property (@(posedge clk) disable iff (!rst_n)
        done && flag_unf |-> flag_inx);

    a_r8_inv_quiet_nan: assert property (@(posedge clk) disable iff (!rst_n)
        done && flag_inv |-> (&sgl_out[OUT_W-2 -: OUT_EW+1]));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind dbl_to_sgl_odd dbl_to_sgl_odd_chk #(
    .OUT_EW(OUT_EW),
    .OUT_FW(OUT_FW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .sgl_out (sgl_out),
    .flag_ovf(flag_ovf),
    .flag_unf(flag_unf),
    .flag_inx(flag_inx),
    .flag_inv(flag_inv)
);

// File: tb/sim_dbl_to_sgl_odd.sv
`timescale 1ns/1ps
module sim_dbl_to_sgl_odd;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] dbl_in = '0;
    logic        dflt_nan = 1'b0;
    logic        flush_zero = 1'b0;
    logic        busy, done;
    logic [31:0] sgl_out;
    logic        flag_ovf, flag_unf, flag_inx, flag_inv;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #4 clk = ~clk;   // 125 MHz

    dbl_to_sgl_odd u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dbl_in(dbl_in),
        .dflt_nan(dflt_nan), .flush_zero(flush_zero),
        .busy(busy), .done(done), .sgl_out(sgl_out),
        .flag_ovf(flag_ovf), .flag_unf(flag_unf),
        .flag_inx(flag_inx), .flag_inv(flag_inv)
    );

    // Expected {inv, inx, unf, ovf, result}, worked out from value and ulp
    function automatic logic [35:0] model(input logic [63:0] d, input bit dn, input bit fz);
        logic        s;
        int          e, p, vexp, ulp, lb;
        logic [51:0] f;
        logic [63:0] sig, m, mask;
        logic        sticky, inv, inx, unf, ovf;
        logic [31:0] res;
        s = d[63]; e = int'(d[62:52]); f = d[51:0];
        inv = 0; inx = 0; unf = 0; ovf = 0; res = '0;
        if (e == 2047) begin
            if (f != 0) begin
                inv = ~f[51];
                res = dn ? 32'h7FC0_0000 : {s, 8'hFF, 1'b1, f[50:29]};
            end else begin
                res = {s, 31'h7F80_0000};
            end
        end else if (e == 0 && f == 0) begin
            res = {s, 31'h0};
        end else begin
            sig  = (e == 0) ? {12'h0, f} : {11'h0, 1'b1, f};
            vexp = (e == 0) ? -1074 : e - 1075;
            p    = (e == 0) ? -1100 : e - 1023;
            if (p > 127) begin
                ovf = 1; inx = 1; res = {s, 31'h7F7F_FFFF};
            end else begin
                ulp = (p < -126) ? -149 : p - 23;
                lb  = ulp - vexp;
                if (lb > 60) lb = 60;
                m      = sig >> lb;
                mask   = (64'd1 << lb) - 64'd1;
                sticky = ((sig & mask) != 0);
                if (p < -126) begin
                    if (fz) begin
                        res = {s, 31'h0}; unf = 1; inx = 1;
                    end else begin
                        res = {s, 8'h00, m[22:1], m[0] | sticky};
                        unf = sticky; inx = sticky;
                    end
                end else begin
                    res = {s, 8'(p + 127), m[22:1], m[0] | sticky};
                    inx = sticky;
                end
            end
        end
        return {inv, inx, unf, ovf, res};
    endfunction

    function automatic string tag_of(input logic [63:0] d, input bit dn, input bit fz);
        int e;
        e = int'(d[62:52]);
        if (e == 2047) return (d[51:0] != 0) ? (dn ? "R9" : "R8") : "R7";
        if (e == 0)    return (fz && d[51:0] != 0) ? "R6" : "R5";
        if (e >= 1151) return "R3";
        if (e <= 896)  return fz ? "R6" : "R4";
        return (d[28:0] != 0) ? "R2" : "R1";
    endfunction

    task automatic report(input string tag, input logic [35:0] got, input logic [35:0] expv,
                          input bit ok, input int lat);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%h expected=%h latency=%0d (expected 3)", tag, got, expv, lat);
        end
    endtask

    task automatic run_conv(input logic [63:0] d, input bit dn, input bit fz);
        logic [35:0] expv, got;
        int          lat;
        @(negedge clk);
        dbl_in = d; dflt_nan = dn; flush_zero = fz; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        expv = model(d, dn, fz);
        got  = {flag_inv, flag_inx, flag_unf, flag_ovf, sgl_out};
        report(tag_of(d, dn, fz), got, expv, (got === expv) && (lat == 3), lat);
    endtask

    function automatic logic [51:0] pattern(input int k);
        case (k)
            0: return 52'h0;
            1: return {52{1'b1}};
            2: return 52'h1;
            3: return 52'h0_0000_2000_0000;   // lowest kept bit only
            default: return lfsr[51:0];
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [35:0] expv, got;
        repeat (3) @(negedge clk);
        // R10: reset state
        got = {flag_inv, flag_inx, flag_unf, flag_ovf, sgl_out};
        checks++;
        if (busy !== 1'b0 || done !== 1'b0 || got !== '0) begin
            failures++;
            $display("FAIL R10 reset got=%h busy=%b done=%b expected=0", got, busy, done);
        end
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R7: every exponent code, five fraction patterns
        for (int e = 0; e < 2048; e++) begin
            for (int k = 0; k < 5; k++) begin
                lfsr = lfsr ^ (lfsr << 13);
                lfsr = lfsr ^ (lfsr >> 7);
                lfsr = lfsr ^ (lfsr << 17);
                run_conv({1'(e + k), 11'(e), pattern(k)}, 1'b0, 1'b0);
            end
        end

        // R6: flush mode across tiny exponents and subnormal inputs
        for (int e = 0; e < 900; e = (e == 0) ? 860 : e + 1) begin
            for (int k = 0; k < 5; k++) begin
                lfsr = lfsr ^ (lfsr << 13);
                lfsr = lfsr ^ (lfsr >> 7);
                lfsr = lfsr ^ (lfsr << 17);
                run_conv({1'(k), 11'(e), pattern(k)}, 1'b0, 1'b1);
            end
        end

        // R8 R9: NaN payloads, quiet and signaling, both NaN modes
        for (int dn = 0; dn < 2; dn++) begin
            run_conv(64'h7FF8_0000_0000_0000, 1'(dn), 1'b0);
            run_conv(64'hFFFF_FFFF_FFFF_FFFF, 1'(dn), 1'b0);
            run_conv(64'h7FF0_0000_0000_0001, 1'(dn), 1'b0);
            run_conv(64'hFFF5_5555_AAAA_AAAA, 1'(dn), 1'b0);
            run_conv(64'h7FFA_BCDE_F000_0000, 1'(dn), 1'b0);
            run_conv(64'h7FF0_0000_2000_0000, 1'(dn), 1'b1);
        end

        // R10: start while busy is ignored
        @(negedge clk);
        dbl_in = 64'h3FF0_0000_0000_0001; dflt_nan = 1'b0; flush_zero = 1'b0; start = 1'b1;
        @(negedge clk);
        dbl_in = 64'hC7F0_0000_0000_0000; dflt_nan = 1'b1; flush_zero = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        expv = model(64'h3FF0_0000_0000_0001, 1'b0, 1'b0);
        got  = {flag_inv, flag_inx, flag_unf, flag_ovf, sgl_out};
        report("R10", got, expv, (got === expv) && done, 3);
        @(negedge clk);
        checks++;
        if (busy !== 1'b0 || done !== 1'b0) begin
            failures++;
            $display("FAIL R10 busy=%b done=%b expected busy=0 done=0 after ignored start", busy, done);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule